// File: doc/BRIEF.md
# Two-Level Tree Magnitude Comparator

This block compares two unsigned 24-bit words and raises exactly one of three active-high flags: greater, equal or less. It is built from six identical 4-bit cascadable comparator slices in two ranks, so no path crosses more than two slices.

The first rank has five slices that work in parallel. The lowest slice covers bits 3:0, and its cascade inputs are tied to the "equal" state. Each of the four upper slices covers five bits. Four of those bits go to the slice's data inputs. The fifth bit, the lowest of its group, is turned into a greater/equal/less triple and fed into the slice's cascade inputs. The upper groups are 8:4, 13:9, 18:14 and 23:19.

The output slice forms a second rank. Its A word is the four greater flags of the upper slices and its B word is their four less flags, with the most significant group at the top bit. The lowest slice's triple drives the output slice's cascade inputs. Words shorter than 24 bits can be compared by holding the unused upper bits of both inputs at zero. The block is purely combinational and has no clock or reset.

Top module: `treeCompare24`

## Requirements
- R1: `greater` is 1 exactly when aWord is larger than bWord, both read as unsigned binary.
- R2: `less` is 1 exactly when aWord is smaller than bWord, both read as unsigned binary.
- R3: `equal` is 1 exactly when every bit of aWord matches the same bit of bWord, including when both words are all zeros or all ones.
- R4: For every input pair, exactly one of `greater`, `equal` and `less` is 1.
- R5: The most significant differing bit decides the result. When the words differ only in bit 23, `greater` equals aWord[23].
- R6: A difference only in bit 0, which the lowest slice resolves through the cascade inputs of the output slice, sets `greater` to aWord[0] and `less` to bWord[0].
- R7: A difference only at a group boundary bit (3, 4, 8, 9, 13, 14, 18, 19, 23) is resolved correctly. This holds whether the bit sits on a slice's data inputs or on its cascade inputs.
- R8: Words narrower than 24 bits whose unused upper bits are 0 in both inputs compare as their narrow values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aWord | input | 24 | First operand, unsigned |
| bWord | input | 24 | Second operand, unsigned |
| greater | output | 1 | High when aWord > bWord |
| equal | output | 1 | High when aWord == bWord |
| less | output | 1 | High when aWord < bWord |

## Verification
Random word pairs exercise the general ordering. Most random pairs differ within the top group, though, so the bench also walks a single differing bit across all 24 positions, in both polarities. This separates faults in the data-input path of a slice from faults in its cascade-fed lowest bit, and from faults in the lowest slice that feeds the output cascade. Equal words (zeros, ones, random) confirm that only the lowest slice's cascade tie produces `equal`. Narrow random words with the upper bits held at zero show that short operands are handled.

// File: rtl/cmpTreePkg.sv
package cmpTreePkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmpRes_t;

  localparam cmpRes_t RES_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

  function automatic cmpRes_t bitPairRes(input logic a, input logic b);
    cmpRes_t r;
    r.gt = a & ~b;
    r.lt = ~a & b;
    r.eq = ~(a ^ b);
    return r;
  endfunction
endpackage

// File: rtl/cmpSlice.sv
module cmpSlice
  import cmpTreePkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] aIn,
  input  logic [SLICE_W-1:0] bIn,
  input  cmpRes_t            cascIn,
  output cmpRes_t            resOut
);
  // Scan upward: a higher differing bit overrides anything below it.
  always_comb begin
    resOut = cascIn;
    for (int i = 0; i < SLICE_W; i++) begin
      if (aIn[i] != bIn[i]) begin
        resOut.gt = aIn[i];
        resOut.eq = 1'b0;
        resOut.lt = bIn[i];
      end
    end
  end

  // R4: a one-hot cascade triple must leave the slice one-hot
  always_comb begin
    if (!$isunknown({aIn, bIn, cascIn}) && $countones(cascIn) == 1)
      assert_slice_onehot_R4: assert ($countones(resOut) == 1);
  end
endmodule

// File: rtl/cmpFirstLevel.sv
module cmpFirstLevel
  import cmpTreePkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int N_UPPER = 4,
  localparam int GROUP_W = SLICE_W + 1,
  localparam int DATA_W  = SLICE_W + N_UPPER * GROUP_W
) (
  input  logic    [DATA_W-1:0]  aWord,
  input  logic    [DATA_W-1:0]  bWord,
  output cmpRes_t               lowRes,
  output cmpRes_t [N_UPPER-1:0] upperRes
);
  cmpSlice #(.SLICE_W(SLICE_W)) lowSlice (
    .aIn   (aWord[SLICE_W-1:0]),
    .bIn   (bWord[SLICE_W-1:0]),
    .cascIn(RES_EQUAL),
    .resOut(lowRes)
  );

  for (genvar k = 0; k < N_UPPER; k++) begin : gUpper
    localparam int BASE = SLICE_W + k * GROUP_W;
    cmpRes_t pairRes;
    assign pairRes = bitPairRes(aWord[BASE], bWord[BASE]);

    cmpSlice #(.SLICE_W(SLICE_W)) upSlice (
      .aIn   (aWord[BASE+SLICE_W:BASE+1]),
      .bIn   (bWord[BASE+SLICE_W:BASE+1]),
      .cascIn(pairRes),
      .resOut(upperRes[k])
    );

    // R7: the cascade-fed boundary bit alone must decide an otherwise equal group
    always_comb begin
      if (!$isunknown({aWord, bWord}) &&
          aWord[BASE+SLICE_W:BASE+1] == bWord[BASE+SLICE_W:BASE+1])
        assert_boundary_bit_R7: assert (upperRes[k].gt == (aWord[BASE] & ~bWord[BASE]));
    end
  end
endmodule

// File: rtl/cmpOutputStage.sv
module cmpOutputStage
  import cmpTreePkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int N_UPPER = 4
) (
  input  cmpRes_t               lowRes,
  input  cmpRes_t [N_UPPER-1:0] upperRes,
  output cmpRes_t               finalRes
);
  logic [N_UPPER-1:0] gtWord;
  logic [N_UPPER-1:0] ltWord;

  for (genvar k = 0; k < N_UPPER; k++) begin : gPack
    assign gtWord[k] = upperRes[k].gt;
    assign ltWord[k] = upperRes[k].lt;
  end

  cmpSlice #(.SLICE_W(N_UPPER)) outSlice (
    .aIn   (gtWord),
    .bIn   (ltWord),
    .cascIn(lowRes),
    .resOut(finalRes)
  );

  // R3: equal is only reported when every first-rank slice reports equal
  always_comb begin
    if (!$isunknown({lowRes, upperRes}) && finalRes.eq)
      assert_equal_needs_all_R3: assert (lowRes.eq && (gtWord | ltWord) == '0);
  end
endmodule

// File: rtl/treeCompare24.sv
module treeCompare24
  import cmpTreePkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int N_UPPER = 4,
  localparam int DATA_W = SLICE_W + N_UPPER * (SLICE_W + 1)
) (
  input  logic [DATA_W-1:0] aWord,
  input  logic [DATA_W-1:0] bWord,
  output logic              greater,
  output logic              equal,
  output logic              less
);
  cmpRes_t               lowRes;
  cmpRes_t [N_UPPER-1:0] upperRes;
  cmpRes_t               finalRes;

  cmpFirstLevel #(.SLICE_W(SLICE_W), .N_UPPER(N_UPPER)) firstLevel (
    .aWord   (aWord),
    .bWord   (bWord),
    .lowRes  (lowRes),
    .upperRes(upperRes)
  );

  cmpOutputStage #(.SLICE_W(SLICE_W), .N_UPPER(N_UPPER)) outStage (
    .lowRes  (lowRes),
    .upperRes(upperRes),
    .finalRes(finalRes)
  );

  assign greater = finalRes.gt;
  assign equal   = finalRes.eq;
  assign less    = finalRes.lt;

  always_comb begin
    if (!$isunknown({aWord, bWord})) begin
      assert_onehot_R4: assert ($countones({greater, equal, less}) == 1);
      assert_greater_R1: assert (greater == (aWord > bWord));
      assert_less_R2: assert (less == (aWord < bWord));
      // R5: a top-bit difference alone decides the result
      if (aWord[DATA_W-1] != bWord[DATA_W-1])
        assert_top_bit_R5: assert (greater == aWord[DATA_W-1]);
    end
  end
endmodule

// File: tb/tb_treeCompare24.sv
module tb_treeCompare24;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic gtOut, eqOut, ltOut;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  treeCompare24 dut (
    .aWord  (aIn),
    .bWord  (bIn),
    .greater(gtOut),
    .equal  (eqOut),
    .less   (ltOut)
  );

  // Behavioural reference: integer ordering, compared after each clock.
  task automatic applyAndCheck(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    longint unsigned ia, ib;
    logic expG, expE, expL;
    @(posedge clk);
    aIn = a;
    bIn = b;
    @(negedge clk);
    ia = longint'(a);
    ib = longint'(b);
    expG = ia > ib;
    expE = ia == ib;
    expL = ia < ib;
    checks++;
    if ({gtOut, eqOut, ltOut} !== {expG, expE, expL}) begin
      fails++;
      $display("FAIL %s a=%h b=%h got g/e/l=%b%b%b expected %b%b%b",
               req, a, b, gtOut, eqOut, ltOut, expG, expE, expL);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset state: zero words must report equal (R3)
    applyAndCheck('0, '0, "R3 zero words");
    applyAndCheck('1, '1, "R3 all ones");
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      applyAndCheck(v, v, "R3 random equal");
    end
    // R6: bit 0 only
    applyAndCheck(24'h000001, 24'h000000, "R6 bit0 a");
    applyAndCheck(24'h000000, 24'h000001, "R6 bit0 b");
    applyAndCheck(24'hA5A5A5, 24'hA5A5A4, "R6 bit0 a over pattern");
    // R5: bit 23 only
    applyAndCheck(24'h800000, 24'h000000, "R5 bit23 a");
    applyAndCheck(24'h7FFFFF, 24'hFFFFFF, "R5 bit23 b");
    // R7: walk a single differing bit over every position, both polarities
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] base;
      base = W'($urandom);
      applyAndCheck(base | (W'(1) << i), base & ~(W'(1) << i), "R7 walk a");
      applyAndCheck(base & ~(W'(1) << i), base | (W'(1) << i), "R7 walk b");
    end
    // R1/R2/R4: random pairs
    for (int i = 0; i < 2000; i++) begin
      applyAndCheck(W'($urandom), W'($urandom), "R1 R2 R4 random");
    end
    // R8: narrow words with upper bits zero
    for (int n = 1; n < W; n++) begin
      for (int j = 0; j < 10; j++) begin
        logic [W-1:0] mask;
        mask = (W'(1) << n) - W'(1);
        applyAndCheck(W'($urandom) & mask, W'($urandom) & mask, "R8 narrow");
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule